// File: doc/BRIEF.md
# Qualified Falling-Edge Event Detector

This block watches two single-bit asynchronous inputs, a qualifier `a_i` and a trigger `b_i`, and raises `x_o` only when the trigger drops from 1 to 0 while the qualifier is already high. The result depends on the order of the input changes, not only on their levels. Reaching a=1, b=0 by raising the qualifier last never fires.

Both inputs pass through two-flop synchronizers. A one-cycle history register lets the block see each edge. A three-state Moore machine holds the result. The states are idle, armed (both inputs high) and detected, encoded 00, 01 and 11. `x_o` is decoded from the detected state alone. Any change on either input while the output is high drops it. The output can only return on a fresh falling trigger with the qualifier held.

Top module: `qual_fall_det`

## Requirements
- R1: While `rst_ni` is low, `x_o` is 0. After reset is released with the inputs already at a=1, b=0, `x_o` stays 0.
- R2: With `a_i`=1 held, a 1-to-0 change on `b_i` sets `x_o` to 1.
- R3: Once set, `x_o` stays 1 for as long as `a_i`=1 and `b_i`=0 both hold.
- R4: A fall of `a_i` while `x_o` is 1 returns `x_o` to 0.
- R5: A rise of `b_i` while `x_o` is 1 returns `x_o` to 0. A later fall of `b_i` with `a_i` still 1 sets it again.
- R6: A rise of `a_i` while `b_i` is already 0 leaves `x_o` at 0.
- R7: If both inputs change in the same sampled cycle, `x_o` stays 0.
- R8: After `x_o` drops, returning to a=1, b=0 by any path other than a falling `b_i` with `a_i` high leaves `x_o` at 0.
- R9: A change on the pins reaches `x_o` on the third rising clock edge after it. The edge that sets `x_o` is the third one after the `b_i` fall, and `x_o` is still unchanged after the second edge.
- R10: The state register never holds the unused code 10, and `x_o` changes only in step with that register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 1 | Qualifier input, asynchronous |
| b_i | input | 1 | Trigger input, asynchronous |
| x_o | output | 1 | Event output, high while the qualified condition holds |

## Verification
Each pin change passes through two synchronizer flops and then the state register, so `x_o` is due on the third rising edge after the change. The bench drives inputs on falling edges and waits exactly three rising edges. It then samples on the next falling edge. For R9 it also samples after only two rising edges, to confirm the output has not moved early. Checks for conditions that must stay held or stay low are repeated on every falling edge across a longer window.

// File: rtl/qfd_pkg.sv
package qfd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_ARMED = 2'b01,
    ST_DET   = 2'b11
  } qfd_state_e;
endpackage

// File: rtl/qfd_sync.sv
module qfd_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[s] <= '0;
        else         stg[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[s] <= '0;
        else         stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/qfd_history.sv
module qfd_history #(
  parameter int WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] cur_i,
  output logic [WIDTH-1:0] prv_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prv_o <= '0;
    else         prv_o <= cur_i;
  end
endmodule

// File: rtl/qfd_fsm.sv
module qfd_fsm
  import qfd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       a_cur_i,
  input  logic       b_cur_i,
  input  logic       a_prv_i,
  input  logic       b_prv_i,
  output logic [1:0] state_o,
  output logic       x_o
);
  qfd_state_e state_q, state_d;

  logic both_hi, qual_lo;
  logic b_fell_a_held;

  assign both_hi       = a_cur_i & b_cur_i;
  assign qual_lo       = a_cur_i & ~b_cur_i;
  // only the trigger moved, qualifier high on both samples
  assign b_fell_a_held = qual_lo & a_prv_i & b_prv_i;

  always_comb begin
    state_d = ST_IDLE;
    case (state_q)
      ST_IDLE:  state_d = both_hi ? ST_ARMED : ST_IDLE;
      ST_ARMED: begin
        if (b_fell_a_held) state_d = ST_DET;
        else if (both_hi)  state_d = ST_ARMED;
        else               state_d = ST_IDLE;
      end
      ST_DET: begin
        if (qual_lo)      state_d = ST_DET;
        else if (both_hi) state_d = ST_ARMED;
        else              state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE; // code 10 recovers
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
  assign x_o     = (state_q == ST_DET);
endmodule

// File: rtl/qual_fall_det.sv
module qual_fall_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  input  logic b_i,
  output logic x_o
);
  localparam int NUM_IN = 2;
  localparam int IDX_A  = 0;
  localparam int IDX_B  = 1;

  logic [NUM_IN-1:0] raw, cur, prv;
  logic [1:0]        state;

  assign raw[IDX_A] = a_i;
  assign raw[IDX_B] = b_i;

  qfd_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (cur)
  );

  qfd_history #(.WIDTH(NUM_IN)) u_hist (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cur_i (cur),
    .prv_o (prv)
  );

  qfd_fsm u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .a_cur_i(cur[IDX_A]),
    .b_cur_i(cur[IDX_B]),
    .a_prv_i(prv[IDX_A]),
    .b_prv_i(prv[IDX_B]),
    .state_o(state),
    .x_o    (x_o)
  );
endmodule

// File: rtl/qual_fall_det_chk.sv
module qual_fall_det_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] cur,
  input logic [1:0] prv,
  input logic [1:0] state,
  input logic       x_o
);
  logic a_s, b_s, a_p, b_p;
  assign a_s = cur[0];
  assign b_s = cur[1];
  assign a_p = prv[0];
  assign b_p = prv[1];

  a_r2_rise_on_qualified_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(x_o) |-> $past(a_s && a_p && b_p && !b_s));

  a_r3_hold_while_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_o && a_s && !b_s) |=> x_o);

  a_r4_drop_on_a_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_o && !a_s) |=> !x_o);

  a_r5_drop_on_b_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_o && b_s) |=> !x_o);

  a_r6_no_set_without_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!x_o && !(a_s && a_p && b_p && !b_s)) |=> !x_o);

  a_r10_no_unused_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state != 2'b10);

  a_r10_x_follows_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(state) |-> $stable(x_o));
endmodule

bind qual_fall_det qual_fall_det_chk u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .cur   (cur),
  .prv   (prv),
  .state (state),
  .x_o   (x_o)
);

// File: tb/tb_qual_fall_det.sv
`timescale 1ns/1ps
module tb_qual_fall_det;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a = 1'b0, b = 1'b0;
  logic x;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  qual_fall_det dut (
    .clk_i (clk),
    .rst_ni(rst_n),
    .a_i   (a),
    .b_i   (b),
    .x_o   (x)
  );

  task automatic check(input string req, input logic exp);
    total++;
    if (x !== exp) begin
      bad++;
      $display("FAIL %s: x_o=%b expected=%b at %0t", req, x, exp, $time);
    end
  endtask

  task automatic drive(input logic na, input logic nb);
    @(negedge clk);
    a = na;
    b = nb;
  endtask

  // result due on third rising edge
  task automatic wait_due();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic reach_detect();
    drive(1'b1, 1'b1); settle();
    drive(1'b1, 1'b0); wait_due();
  endtask

  task automatic t_reset();
    a = 1'b1; b = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 during reset", 1'b0);
    rst_n = 1'b1;
    settle();
    check("R1 release at a=1 b=0", 1'b0);
  endtask

  task automatic t_detect_and_latency();
    drive(1'b1, 1'b1); settle();
    check("R2 armed, not yet fired", 1'b0);
    drive(1'b1, 1'b0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R9 unchanged after two edges", 1'b0);
    @(posedge clk);
    @(negedge clk);
    check("R2 set on third edge", 1'b1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R3 held", 1'b1);
    end
  endtask

  task automatic t_drop_on_a();
    reach_detect();
    check("R4 pre", 1'b1);
    drive(1'b0, 1'b0); wait_due();
    check("R4 a fall clears", 1'b0);
    drive(1'b1, 1'b0); wait_due();
    check("R8 a back high, no refire", 1'b0);
    settle();
    check("R8 stays low", 1'b0);
  endtask

  task automatic t_drop_on_b();
    reach_detect();
    check("R5 pre", 1'b1);
    drive(1'b1, 1'b1); wait_due();
    check("R5 b rise clears", 1'b0);
    drive(1'b1, 1'b0); wait_due();
    check("R5 refire on new b fall", 1'b1);
  endtask

  task automatic t_a_rise_b_low();
    drive(1'b0, 1'b0); settle();
    drive(1'b1, 1'b0); wait_due();
    check("R6 a rise with b low", 1'b0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R6 stays low", 1'b0);
    end
  endtask

  task automatic t_simultaneous();
    drive(1'b0, 1'b1); settle();
    drive(1'b1, 1'b0); wait_due();
    check("R7 both change 01->10", 1'b0);
    settle();
    check("R7 still low", 1'b0);
    drive(1'b1, 1'b1); settle();
    drive(1'b0, 1'b0); wait_due();
    check("R7 both change 11->00", 1'b0);
    drive(1'b1, 1'b1); settle();
    drive(1'b1, 1'b0); wait_due();
    check("R7 normal path still fires", 1'b1);
  endtask

  task automatic t_reset_mid();
    reach_detect();
    check("R1 pre", 1'b1);
    #1 rst_n = 1'b0;
    #1 check("R1 async clear", 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    settle();
    check("R1 no fire after release", 1'b0);
  endtask

  initial begin
    t_reset();
    t_detect_and_latency();
    t_drop_on_a();
    t_drop_on_b();
    t_a_rise_b_low();
    t_simultaneous();
    t_reset_mid();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule